// File: doc/BRIEF.md
# Grouped Interrupt Status and Mask Block

This block collects single-cycle interrupt request pulses from a set of sources, such as DMA channels, and combines them into one level-sensitive request line for an interrupt controller. Each source has a sticky status flag that only hardware can set, and a per-source disable bit. The status flags record every event whatever the disable bits hold, so software can poll a disabled source. Only sources that are enabled contribute to the combined request.

Software reaches both registers through a small synchronous register port: an address, a write strobe, write data and a read data bus. The read bus shows the addressed register in the same cycle. A status write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 untouched. An interrupt handler can therefore acknowledge exactly the sources it serviced, and the other pending events survive. The combined request is registered. It tracks the status and disable registers edge for edge, so a clear removes the request at the same clock edge that clears the flag.

Top module: `irq_grp_ctrl`

## Requirements
- R1: After reset all status flags read 0, all disable bits read 1, and `group_irq` is 0.
- R2: A pulse on `src_req[i]` sets status flag i at the next rising clock edge, whatever disable bit i holds.
- R3: Reads have no side effects. Address 0 returns the status flags, address 1 returns the disable bits, and addresses 2 and 3 return 0. Bit i of each register belongs to source i.
- R4: A write to address 0 clears every status flag whose data bit is 0 and leaves every flag whose data bit is 1 at its prior value.
- R5: Software cannot set a status flag. Writing 1 to a clear flag leaves it at 0.
- R6: When a source pulse and a write of 0 hit the same status flag in the same cycle, the flag is set after the edge.
- R7: A write to address 1 loads all disable bits from the write data. A bit value of 0 enables that source and 1 disables it.
- R8: `group_irq` equals the OR over all i of (status i AND NOT disable i). It updates at the same edge as the registers it depends on, so clearing a flag or disabling a source removes the request at that edge.
- R9: Writes to addresses 2 and 3 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_req | input | NUM_SRC | Request pulses, one bit per source, synchronous to clk |
| reg_addr | input | 2 | Register address: 0 status, 1 disable |
| reg_wr_en | input | 1 | Write strobe for the addressed register |
| reg_wr_data | input | NUM_SRC | Write data |
| reg_rd_data | output | NUM_SRC | Contents of the addressed register, combinational |
| group_irq | output | 1 | Registered, level-sensitive combined request |

## Verification
The hardest case to reach from the ports is a collision on one status flag: a source pulse and a write of 0 to the same flag in the same cycle. The driver produces it by asserting a request bit in the same step as a status write of 0x00. A follow-up read then shows that this flag alone survived. Partial clears of a group with several flags pending, with the disable register set so that only some of them reach the output, show that clearing and the combined request both act per bit.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_RSVD2  = 2'd2,
    REG_RSVD3  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_grp_rst_sync.sv
module irq_grp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_grp_status.sv
module irq_grp_status #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_pulse,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] status_d,
  output logic [NUM_SRC-1:0] status_q
);
  logic upd_en;

  // Per-bit flag: a hardware set beats a software clear of the same bit.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic clr_bit;
    assign clr_bit     = wr_en & ~wr_data[i];
    assign status_d[i] = set_pulse[i] | (status_q[i] & ~clr_bit);
  end

  always_comb upd_en = wr_en | (|set_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end
endmodule

// File: rtl/irq_grp_mask.sv
module irq_grp_mask #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] mask_d,
  output logic [NUM_SRC-1:0] mask_q
);
  always_comb mask_d = wr_en ? wr_data : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '1;
    else if (wr_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_grp_out.sv
module irq_grp_out #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_d,
  input  logic [NUM_SRC-1:0] mask_d,
  output logic               irq_q
);
  logic irq_d;

  // Built from next-state values so the output moves with the registers.
  always_comb irq_d = |(status_d & ~mask_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_grp_ctrl.sv
module irq_grp_ctrl #(
  parameter int NUM_SRC = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_req,
  input  logic [irq_grp_pkg::ADDR_W-1:0]  reg_addr,
  input  logic                            reg_wr_en,
  input  logic [NUM_SRC-1:0]              reg_wr_data,
  output logic [NUM_SRC-1:0]              reg_rd_data,
  output logic                            group_irq
);
  import irq_grp_pkg::*;

  logic               rst_sync_n;
  logic               wr_status;
  logic               wr_mask;
  logic [NUM_SRC-1:0] status_d;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0] mask_q;

  irq_grp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_status = reg_wr_en && (reg_addr == REG_STATUS);
    wr_mask   = reg_wr_en && (reg_addr == REG_MASK);
  end

  irq_grp_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_pulse (src_req),
    .wr_en     (wr_status),
    .wr_data   (reg_wr_data),
    .status_d  (status_d),
    .status_q  (status_q)
  );

  irq_grp_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_mask),
    .wr_data (reg_wr_data),
    .mask_d  (mask_d),
    .mask_q  (mask_q)
  );

  irq_grp_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .status_d (status_d),
    .mask_d   (mask_d),
    .irq_q    (group_irq)
  );

  always_comb begin
    case (reg_addr)
      REG_STATUS: reg_rd_data = status_q;
      REG_MASK:   reg_rd_data = mask_q;
      default:    reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_grp_ctrl_chk.sv
module irq_grp_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_sync_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic [1:0]         reg_addr,
  input logic               reg_wr_en,
  input logic [NUM_SRC-1:0] reg_wr_data,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               group_irq
);
  // R1: values held while the internal reset is active
  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (status_q == '0 && mask_q == '1 && !group_irq));

  // R2: a pulse sets its flag at the next edge
  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_req != '0) |=> ((status_q & $past(src_req)) == $past(src_req)));

  // R4 and R6: per-bit write-zero clear, a pulse wins
  assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_en && reg_addr == 2'd0) |=>
      (status_q == (($past(status_q) & $past(reg_wr_data)) | $past(src_req))));

  // R5: a flag never rises without its source
  assert_no_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(src_req)) == '0));

  // R7: disable register load
  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_en && reg_addr == 2'd1) |=> (mask_q == $past(reg_wr_data)));

  // R9: disable register untouched by other accesses
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_wr_en && reg_addr == 2'd1) |=> $stable(mask_q));

  // R8: combined output consistent with the registers
  assert_group_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    group_irq == (|(status_q & ~mask_q)));
endmodule

bind irq_grp_ctrl irq_grp_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .src_req     (src_req),
  .reg_addr    (reg_addr),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .group_irq   (group_irq)
);

// File: tb/irq_grp_ctrl_test.sv
module irq_grp_ctrl_test;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] src_req;
  logic [1:0]   reg_addr;
  logic         reg_wr_en;
  logic [N-1:0] reg_wr_data;
  logic [N-1:0] reg_rd_data;
  logic         group_irq;

  irq_grp_ctrl #(.NUM_SRC(N)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req     (src_req),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .group_irq   (group_irq)
  );

  typedef struct {
    logic [N-1:0] exp_rd;
    logic         exp_irq;
    int           rid;
  } item_t;

  item_t        sb_q[$];
  int           n_cmp;
  int           n_bad;
  logic [N-1:0] m_st;
  logic [N-1:0] m_mk;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Driver: drives one cycle and pushes what the ports must show before the edge.
  task automatic step(input logic [N-1:0] req, input logic [1:0] addr,
                      input logic we, input logic [N-1:0] wd, input int rid);
    item_t it;
    logic [N-1:0] clr;
    @(negedge clk);
    src_req     = req;
    reg_addr    = addr;
    reg_wr_en   = we;
    reg_wr_data = wd;
    it.exp_rd   = (addr == 2'd0) ? m_st : (addr == 2'd1) ? m_mk : '0;
    it.exp_irq  = |(m_st & ~m_mk);
    it.rid      = rid;
    sb_q.push_back(it);
    clr  = (we && addr == 2'd0) ? ~wd : '0;
    m_st = req | (m_st & ~clr);
    if (we && addr == 2'd1) m_mk = wd;
  endtask

  // Monitor: compares shortly after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (reg_rd_data !== it.exp_rd) begin
          n_bad++;
          $display("FAIL R%0d read data: actual %h expected %h", it.rid, reg_rd_data, it.exp_rd);
        end
        n_cmp++;
        if (group_irq !== it.exp_irq) begin
          n_bad++;
          $display("FAIL R%0d group_irq: actual %b expected %b", it.rid, group_irq, it.exp_irq);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    m_st = '0; m_mk = '1;
    rst_n = 1'b0; src_req = '0; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step('0, 2'd0, 0, '0, 1);            // R1 status reset value
    step('0, 2'd1, 0, '0, 1);            // R1 mask reset value
    step(8'h01, 2'd0, 0, '0, 2);         // R2 pulse while disabled
    step('0, 2'd0, 0, '0, 2);            // R2 flag visible, irq stays low (R8)
    step('0, 2'd0, 0, '0, 3);            // R3 repeated read has no side effect
    step('0, 2'd1, 1, 8'hFE, 7);         // R7 enable source 0
    step('0, 2'd1, 0, '0, 7);            // R7 readback, irq high (R8)
    step(8'h28, 2'd0, 0, '0, 2);         // R2 pulses on bits 3 and 5
    step('0, 2'd0, 0, '0, 2);
    step('0, 2'd0, 1, 8'hF7, 4);         // R4 clear only bit 3
    step('0, 2'd0, 0, '0, 4);
    step('0, 2'd0, 1, 8'hFF, 5);         // R5 ones write sets nothing
    step('0, 2'd0, 0, '0, 5);
    step(8'h20, 2'd0, 1, 8'h00, 6);      // R6 set beats clear on bit 5
    step('0, 2'd0, 0, '0, 6);
    step('0, 2'd2, 1, 8'h00, 9);         // R9 write to address 2
    step('0, 2'd3, 1, 8'hFF, 9);         // R9 write to address 3
    step('0, 2'd2, 0, '0, 3);            // R3 unused address reads 0
    step('0, 2'd1, 0, '0, 9);            // R9 mask unchanged
    step('0, 2'd0, 0, '0, 9);            // R9 status unchanged
    step('0, 2'd1, 1, 8'hDF, 8);         // R8 enable bit 5 -> irq high
    step('0, 2'd0, 0, '0, 8);
    step('0, 2'd1, 1, 8'hFF, 8);         // R8 disable all -> irq drops
    step('0, 2'd0, 0, '0, 8);
    step('0, 2'd1, 1, 8'h00, 7);         // R7 enable all
    step(8'h81, 2'd0, 0, '0, 2);
    step('0, 2'd0, 1, 8'h7F, 4);         // R4 clear bit 7, bits 0 and 5 stay
    step('0, 2'd0, 1, 8'h00, 8);         // R8 clear all -> irq drops at the edge
    step('0, 2'd0, 0, '0, 8);
    step('0, 2'd1, 0, '0, 3);
    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule